// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block switches one gated logic domain on and off. A one-cycle request starts a fixed, ordered sequence on the domain's control lines. These are two power-switch enables, isolation, an active-low domain reset, a clock gate, and one power-down line per memory bank. The sequence also raises or drops a bus-protection request toward the interconnect, so that no transaction is in flight while the domain is cut.

Between steps the sequencer waits on several returns: the two switch status inputs, the memory bank acknowledgements and the bus-protection grant. Every wait is bounded by a cycle counter. The block reports progress with a busy level, a one-cycle completion pulse, or a one-cycle timeout pulse. Parameters set the number of memory banks, which banks return an acknowledgement, whether bus protection is used, and the wait bound.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset the domain is off. Both switch enables are 0, `iso_en`=1, `dom_rst_n`=0, `clk_gate`=1 (1 means gated), all `mem_pdn` bits are 1, and `prot_req` equals 1 when bus protection is used. `busy`, `done` and `timeout_err` are 0.
- R2: Power-up raises `sw_en_pri` first. `sw_en_sec` rises in the following cycle.
- R3: Power-up goes past the switch stage only when both `sw_stat_pri` and `sw_stat_sec` read 1. While the two disagree, no further control output changes.
- R4: Power-up then runs these steps, one output change per clock cycle: ungate the clock, drop isolation, raise `dom_rst_n`, clear all `mem_pdn` bits. It waits until every acknowledging bank reads 0 on `mem_ack`. It then drops `prot_req` and waits for `prot_ack` to read 0.
- R5: Power-down first raises `prot_req` and waits for `prot_ack`=1. Only then does it set all `mem_pdn` bits, and it waits until every acknowledging bank reads 1.
- R6: Power-down continues with these steps, one per cycle: raise isolation, drive `dom_rst_n` low, gate the clock, drop `sw_en_pri`, drop `sw_en_sec`. It then waits until both status inputs read 0.
- R7: `mem_ack` bits of banks outside `ACK_MASK` have no effect. With `ACK_MASK`=0 both memory waits are skipped.
- R8: With `USE_BUS_PROT`=0, `prot_req` stays 0 and the sequences have no protection steps.
- R9: Every wait lasts at most `TIMEOUT_CYCLES` cycles. On expiry the block pulses `timeout_err` for one cycle, returns to idle, and keeps all control outputs as they were. A power-up stuck at the switch stage keeps `busy` high for `TIMEOUT_CYCLES`+2 cycles. A power-down stuck at the protection grant keeps it high for `TIMEOUT_CYCLES`+1 cycles.
- R10: `req_on` and `req_off` have no effect while `busy` is high. When idle, `req_on` takes precedence.
- R11: `busy` rises in the cycle after an accepted request. On success `done` is high for exactly one cycle, and `busy` falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_on | input | 1 | One-cycle power-up request |
| req_off | input | 1 | One-cycle power-down request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| timeout_err | output | 1 | One-cycle pulse when a wait expires |
| sw_en_pri | output | 1 | Primary power-switch enable |
| sw_en_sec | output | 1 | Secondary power-switch enable |
| sw_stat_pri | input | 1 | Primary switch status |
| sw_stat_sec | input | 1 | Secondary switch status |
| iso_en | output | 1 | Domain output isolation, 1 = isolated |
| dom_rst_n | output | 1 | Domain reset, active low |
| clk_gate | output | 1 | Domain clock gate, 1 = clock stopped |
| mem_pdn | output | NUM_BANKS | Per-bank memory power-down, 1 = powered down |
| mem_ack | input | NUM_BANKS | Per-bank power-down acknowledgement |
| prot_req | output | 1 | Bus-protection request to the interconnect |
| prot_ack | input | 1 | Bus-protection granted |

## Verification
The hard cases are the stalled waits. These are a status pair stuck in disagreement, memory acknowledgements that never settle, and a protection grant that never arrives. Each must end in a timeout after an exact number of cycles, with outputs frozen mid-sequence. The bench drives the block from a behavioural model of the switches, banks and interconnect. Each return path of the model has a hold control, so any single return can be frozen at its current value. The model also drives deliberately inverted acknowledgements on the banks outside the mask. A second instance with no acknowledging banks and no protection covers the skipped steps.

// File: rtl/pds_pkg.sv
package pds_pkg;

  typedef enum logic [4:0] {
    S_IDLE,
    S_UP_PRI, S_UP_SEC, S_UP_WSTAT, S_UP_CLK, S_UP_ISO, S_UP_RST,
    S_UP_MEM, S_UP_WMEM, S_UP_PROT, S_UP_WPROT,
    S_DN_PROT, S_DN_WPROT, S_DN_MEM, S_DN_WMEM, S_DN_ISO, S_DN_RST,
    S_DN_CLK, S_DN_PRI, S_DN_SEC, S_DN_WSTAT
  } seq_state_e;

  function automatic logic is_wait_state(seq_state_e s);
    return (s == S_UP_WSTAT) || (s == S_UP_WMEM) || (s == S_UP_WPROT) ||
           (s == S_DN_WPROT) || (s == S_DN_WMEM) || (s == S_DN_WSTAT);
  endfunction

endpackage

// File: rtl/pds_wait_timer.sv
module pds_wait_timer #(
  parameter int unsigned TIMEOUT_CYCLES = 64,
  localparam int unsigned CW = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_wait,
  output logic expired
);

  localparam logic [CW-1:0] RELOAD = CW'(TIMEOUT_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // Count only inside a wait; reload whenever the sequencer is elsewhere.
  assign cnt_en = !in_wait || (cnt_q != '0);

  always_comb begin
    if (!in_wait) cnt_d = RELOAD;
    else          cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RELOAD;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = in_wait && (cnt_q == '0);

  a_r9_fresh_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_wait) |-> !expired);

endmodule

// File: rtl/pds_ack_eval.sv
module pds_ack_eval #(
  parameter int unsigned            NUM_BANKS = 4,
  parameter logic [NUM_BANKS-1:0]   ACK_MASK  = '1
) (
  input  logic                 sw_stat_pri,
  input  logic                 sw_stat_sec,
  input  logic [NUM_BANKS-1:0] mem_ack,
  output logic                 stat_all_on,
  output logic                 stat_all_off,
  output logic                 mem_all_clear,
  output logic                 mem_all_set
);

  assign stat_all_on  = sw_stat_pri && sw_stat_sec;
  assign stat_all_off = !sw_stat_pri && !sw_stat_sec;

  generate
    if (ACK_MASK == '0) begin : g_no_ack
      logic unused_ack;
      assign unused_ack    = ^mem_ack;
      assign mem_all_clear = 1'b1;
      assign mem_all_set   = 1'b1;
    end else begin : g_ack
      logic [NUM_BANKS-1:0] seen;
      assign seen          = mem_ack & ACK_MASK;
      assign mem_all_clear = (seen == '0);
      assign mem_all_set   = (seen == ACK_MASK);
    end
  endgenerate

endmodule

// File: rtl/pds_seq_fsm.sv
module pds_seq_fsm
  import pds_pkg::*;
#(
  parameter int unsigned NUM_BANKS    = 4,
  parameter bit          HAS_ACK      = 1'b1,
  parameter bit          USE_BUS_PROT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_on,
  input  logic                 req_off,
  input  logic                 stat_all_on,
  input  logic                 stat_all_off,
  input  logic                 mem_all_clear,
  input  logic                 mem_all_set,
  input  logic                 prot_ack,
  input  logic                 tmo_expired,
  output logic                 in_wait,
  output logic                 busy,
  output logic                 done,
  output logic                 timeout_err,
  output logic                 sw_en_pri,
  output logic                 sw_en_sec,
  output logic                 iso_en,
  output logic                 dom_rst_n,
  output logic                 clk_gate,
  output logic [NUM_BANKS-1:0] mem_pdn,
  output logic                 prot_req
);

  seq_state_e state_q, state_d;
  logic done_d, err_d;
  logic pri_d, sec_d, iso_d, rstn_d, gate_d, prot_d;
  logic [NUM_BANKS-1:0] pdn_d;

  // Power-up tail after the memory step, shared by several states.
  function automatic seq_state_e after_up_mem();
    return USE_BUS_PROT ? S_UP_PROT : S_IDLE;
  endfunction

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    pri_d   = sw_en_pri;
    sec_d   = sw_en_sec;
    iso_d   = iso_en;
    rstn_d  = dom_rst_n;
    gate_d  = clk_gate;
    pdn_d   = mem_pdn;
    prot_d  = prot_req;
    unique case (state_q)
      S_IDLE: begin
        if (req_on)       state_d = S_UP_PRI;
        else if (req_off) state_d = USE_BUS_PROT ? S_DN_PROT : S_DN_MEM;
      end
      S_UP_PRI:   begin pri_d  = 1'b1; state_d = S_UP_SEC; end
      S_UP_SEC:   begin sec_d  = 1'b1; state_d = S_UP_WSTAT; end
      S_UP_WSTAT: begin
        if (stat_all_on)      state_d = S_UP_CLK;
        else if (tmo_expired) begin err_d = 1'b1; state_d = S_IDLE; end
      end
      S_UP_CLK:   begin gate_d = 1'b0; state_d = S_UP_ISO; end
      S_UP_ISO:   begin iso_d  = 1'b0; state_d = S_UP_RST; end
      S_UP_RST:   begin rstn_d = 1'b1; state_d = S_UP_MEM; end
      S_UP_MEM: begin
        pdn_d = '0;
        if (HAS_ACK) state_d = S_UP_WMEM;
        else begin
          state_d = after_up_mem();
          done_d  = !USE_BUS_PROT;
        end
      end
      S_UP_WMEM: begin
        if (mem_all_clear) begin
          state_d = after_up_mem();
          done_d  = !USE_BUS_PROT;
        end else if (tmo_expired) begin err_d = 1'b1; state_d = S_IDLE; end
      end
      S_UP_PROT:  begin prot_d = 1'b0; state_d = S_UP_WPROT; end
      S_UP_WPROT: begin
        if (!prot_ack)        begin done_d = 1'b1; state_d = S_IDLE; end
        else if (tmo_expired) begin err_d  = 1'b1; state_d = S_IDLE; end
      end
      S_DN_PROT:  begin prot_d = 1'b1; state_d = S_DN_WPROT; end
      S_DN_WPROT: begin
        if (prot_ack)         state_d = S_DN_MEM;
        else if (tmo_expired) begin err_d = 1'b1; state_d = S_IDLE; end
      end
      S_DN_MEM: begin
        pdn_d   = '1;
        state_d = HAS_ACK ? S_DN_WMEM : S_DN_ISO;
      end
      S_DN_WMEM: begin
        if (mem_all_set)      state_d = S_DN_ISO;
        else if (tmo_expired) begin err_d = 1'b1; state_d = S_IDLE; end
      end
      S_DN_ISO:   begin iso_d  = 1'b1; state_d = S_DN_RST; end
      S_DN_RST:   begin rstn_d = 1'b0; state_d = S_DN_CLK; end
      S_DN_CLK:   begin gate_d = 1'b1; state_d = S_DN_PRI; end
      S_DN_PRI:   begin pri_d  = 1'b0; state_d = S_DN_SEC; end
      S_DN_SEC:   begin sec_d  = 1'b0; state_d = S_DN_WSTAT; end
      S_DN_WSTAT: begin
        if (stat_all_off)     begin done_d = 1'b1; state_d = S_IDLE; end
        else if (tmo_expired) begin err_d  = 1'b1; state_d = S_IDLE; end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      sw_en_pri   <= 1'b0;
      sw_en_sec   <= 1'b0;
      iso_en      <= 1'b1;
      dom_rst_n   <= 1'b0;
      clk_gate    <= 1'b1;
      mem_pdn     <= '1;
      prot_req    <= USE_BUS_PROT;
    end else begin
      state_q     <= state_d;
      done        <= done_d;
      timeout_err <= err_d;
      sw_en_pri   <= pri_d;
      sw_en_sec   <= sec_d;
      iso_en      <= iso_d;
      dom_rst_n   <= rstn_d;
      clk_gate    <= gate_d;
      mem_pdn     <= pdn_d;
      prot_req    <= prot_d;
    end
  end

  assign busy    = (state_q != S_IDLE);
  assign in_wait = is_wait_state(state_q);

  a_r2_sec_after_pri: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en_sec) |-> $past(sw_en_pri));

  a_r3_mixed_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_UP_WSTAT && !stat_all_on && !tmo_expired) |=> (state_q == S_UP_WSTAT));

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sw_en_pri ^ $past(sw_en_pri), sw_en_sec ^ $past(sw_en_sec),
                iso_en ^ $past(iso_en), dom_rst_n ^ $past(dom_rst_n),
                clk_gate ^ $past(clk_gate), |(mem_pdn ^ $past(mem_pdn)),
                prot_req ^ $past(prot_req)}) <= 1);

  a_r5_mem_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (USE_BUS_PROT && $rose(mem_pdn[0])) |-> $past(prot_ack, 2));

  a_r6_sec_drops_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_en_sec) |-> (!sw_en_pri && $past(!sw_en_pri)));

  a_r9_err_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (!busy && !done));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq #(
  parameter int unsigned          NUM_BANKS      = 4,
  parameter logic [NUM_BANKS-1:0] ACK_MASK       = 4'b1011,
  parameter bit                   USE_BUS_PROT   = 1'b1,
  parameter int unsigned          TIMEOUT_CYCLES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_on,
  input  logic                 req_off,
  output logic                 busy,
  output logic                 done,
  output logic                 timeout_err,
  output logic                 sw_en_pri,
  output logic                 sw_en_sec,
  input  logic                 sw_stat_pri,
  input  logic                 sw_stat_sec,
  output logic                 iso_en,
  output logic                 dom_rst_n,
  output logic                 clk_gate,
  output logic [NUM_BANKS-1:0] mem_pdn,
  input  logic [NUM_BANKS-1:0] mem_ack,
  output logic                 prot_req,
  input  logic                 prot_ack
);

  localparam bit HAS_ACK = (ACK_MASK != '0);

  logic stat_all_on, stat_all_off, mem_all_clear, mem_all_set;
  logic in_wait, tmo_expired;

  pds_ack_eval #(
    .NUM_BANKS (NUM_BANKS),
    .ACK_MASK  (ACK_MASK)
  ) u_eval (
    .sw_stat_pri   (sw_stat_pri),
    .sw_stat_sec   (sw_stat_sec),
    .mem_ack       (mem_ack),
    .stat_all_on   (stat_all_on),
    .stat_all_off  (stat_all_off),
    .mem_all_clear (mem_all_clear),
    .mem_all_set   (mem_all_set)
  );

  pds_wait_timer #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_wait (in_wait),
    .expired (tmo_expired)
  );

  pds_seq_fsm #(
    .NUM_BANKS    (NUM_BANKS),
    .HAS_ACK      (HAS_ACK),
    .USE_BUS_PROT (USE_BUS_PROT)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_on        (req_on),
    .req_off       (req_off),
    .stat_all_on   (stat_all_on),
    .stat_all_off  (stat_all_off),
    .mem_all_clear (mem_all_clear),
    .mem_all_set   (mem_all_set),
    .prot_ack      (prot_ack),
    .tmo_expired   (tmo_expired),
    .in_wait       (in_wait),
    .busy          (busy),
    .done          (done),
    .timeout_err   (timeout_err),
    .sw_en_pri     (sw_en_pri),
    .sw_en_sec     (sw_en_sec),
    .iso_en        (iso_en),
    .dom_rst_n     (dom_rst_n),
    .clk_gate      (clk_gate),
    .mem_pdn       (mem_pdn),
    .prot_req      (prot_req)
  );

  a_r8_no_prot_req: assert property (@(posedge clk) disable iff (!rst_n)
    (!USE_BUS_PROT && $past(busy)) |-> !prot_req);

endmodule

// File: tb/pwr_domain_seq_tb.sv
`timescale 1ns/1ps

module pds_env_model #(
  parameter int unsigned          NB       = 4,
  parameter logic [NB-1:0]        MASK     = '1,
  parameter bit                   PROT_RST = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_en_pri,
  input  logic          sw_en_sec,
  input  logic          iso_en,
  input  logic          dom_rst_n,
  input  logic          clk_gate,
  input  logic [NB-1:0] mem_pdn,
  input  logic          prot_req,
  input  logic          hold_sec,
  input  logic          hold_ack,
  input  logic          hold_prot,
  input  logic          clr_log,
  output logic          stat_pri,
  output logic          stat_sec,
  output logic [NB-1:0] ack,
  output logic          prot_ack
);
  logic [2:0]    p_sh;
  logic [4:0]    s_sh;
  logic [NB-1:0] a_s0, a_s1, a_s2;
  logic [1:0]    r_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_sh <= '0; s_sh <= '0;
      a_s0 <= '1; a_s1 <= '1; a_s2 <= '1;
      r_sh <= {2{PROT_RST}};
    end else begin
      p_sh <= {p_sh[1:0], sw_en_pri};
      if (!hold_sec)  s_sh <= {s_sh[3:0], sw_en_sec};
      if (!hold_ack) begin a_s0 <= mem_pdn; a_s1 <= a_s0; a_s2 <= a_s1; end
      if (!hold_prot) r_sh <= {r_sh[0], prot_req};
    end
  end

  assign stat_pri = p_sh[2];
  assign stat_sec = s_sh[4];
  assign ack      = (a_s2 & MASK) | (~mem_pdn & ~MASK);
  assign prot_ack = r_sh[1];

  // Event log of control-output changes, codes defined in the bench.
  int ev_cnt;
  int ev_log [32];
  logic pv_pri, pv_sec, pv_iso, pv_rst, pv_gate, pv_prot;
  logic [NB-1:0] pv_pdn;

  task automatic push(int c);
    if (ev_cnt < 32) ev_log[ev_cnt] = c;
    ev_cnt++;
  endtask

  always @(posedge clk) begin
    if (clr_log) ev_cnt = 0;
    else if (rst_n) begin
      if (sw_en_pri != pv_pri) push(sw_en_pri ? 1 : 13);
      if (sw_en_sec != pv_sec) push(sw_en_sec ? 2 : 14);
      if (clk_gate  != pv_gate) push(clk_gate ? 12 : 3);
      if (iso_en    != pv_iso) push(iso_en ? 10 : 4);
      if (dom_rst_n != pv_rst) push(dom_rst_n ? 5 : 11);
      if (mem_pdn   != pv_pdn) push((mem_pdn == '0) ? 6 : 9);
      if (prot_req  != pv_prot) push(prot_req ? 8 : 7);
    end
    pv_pri = sw_en_pri; pv_sec = sw_en_sec; pv_gate = clk_gate; pv_iso = iso_en;
    pv_rst = dom_rst_n; pv_pdn = mem_pdn; pv_prot = prot_req;
  end
endmodule

module pwr_domain_seq_tb;
  localparam int unsigned NB = 4;
  localparam int unsigned TMO = 20;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // DUT A: default masks, bus protection on
  logic a_on, a_off, a_busy, a_done, a_err, a_pri, a_sec, a_spri, a_ssec;
  logic a_iso, a_rstn, a_gate, a_prot, a_pack;
  logic [NB-1:0] a_pdn, a_ack;
  logic a_hsec, a_hack, a_hprot, a_clr;
  // DUT B: no acknowledging banks, no bus protection
  logic b_on, b_off, b_busy, b_done, b_err, b_pri, b_sec, b_spri, b_ssec;
  logic b_iso, b_rstn, b_gate, b_prot, b_pack;
  logic [NB-1:0] b_pdn, b_ack;
  logic b_clr;

  pwr_domain_seq #(.NUM_BANKS(NB), .ACK_MASK(4'b1011), .USE_BUS_PROT(1'b1),
                   .TIMEOUT_CYCLES(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_on(a_on), .req_off(a_off), .busy(a_busy),
    .done(a_done), .timeout_err(a_err), .sw_en_pri(a_pri), .sw_en_sec(a_sec),
    .sw_stat_pri(a_spri), .sw_stat_sec(a_ssec), .iso_en(a_iso), .dom_rst_n(a_rstn),
    .clk_gate(a_gate), .mem_pdn(a_pdn), .mem_ack(a_ack), .prot_req(a_prot),
    .prot_ack(a_pack));

  pds_env_model #(.NB(NB), .MASK(4'b1011), .PROT_RST(1'b1)) u_env_a (
    .clk(clk), .rst_n(rst_n), .sw_en_pri(a_pri), .sw_en_sec(a_sec), .iso_en(a_iso),
    .dom_rst_n(a_rstn), .clk_gate(a_gate), .mem_pdn(a_pdn), .prot_req(a_prot),
    .hold_sec(a_hsec), .hold_ack(a_hack), .hold_prot(a_hprot), .clr_log(a_clr),
    .stat_pri(a_spri), .stat_sec(a_ssec), .ack(a_ack), .prot_ack(a_pack));

  pwr_domain_seq #(.NUM_BANKS(NB), .ACK_MASK(4'b0000), .USE_BUS_PROT(1'b0),
                   .TIMEOUT_CYCLES(TMO)) u_dut_min (
    .clk(clk), .rst_n(rst_n), .req_on(b_on), .req_off(b_off), .busy(b_busy),
    .done(b_done), .timeout_err(b_err), .sw_en_pri(b_pri), .sw_en_sec(b_sec),
    .sw_stat_pri(b_spri), .sw_stat_sec(b_ssec), .iso_en(b_iso), .dom_rst_n(b_rstn),
    .clk_gate(b_gate), .mem_pdn(b_pdn), .mem_ack(b_ack), .prot_req(b_prot),
    .prot_ack(b_pack));

  pds_env_model #(.NB(NB), .MASK(4'b0000), .PROT_RST(1'b0)) u_env_b (
    .clk(clk), .rst_n(rst_n), .sw_en_pri(b_pri), .sw_en_sec(b_sec), .iso_en(b_iso),
    .dom_rst_n(b_rstn), .clk_gate(b_gate), .mem_pdn(b_pdn), .prot_req(b_prot),
    .hold_sec(1'b0), .hold_ack(1'b0), .hold_prot(1'b0), .clr_log(b_clr),
    .stat_pri(b_spri), .stat_sec(b_ssec), .ack(b_ack), .prot_ack(b_pack));

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic chk_log(bit sel_b, string rq, int n, int e [8]);
    int cnt;
    cnt = sel_b ? u_env_b.ev_cnt : u_env_a.ev_cnt;
    chk({rq, " event count"}, cnt, n);
    for (int i = 0; i < n && i < cnt; i++)
      chk({rq, " event order"}, sel_b ? u_env_b.ev_log[i] : u_env_a.ev_log[i], e[i]);
  endtask

  // Issue a request and follow it to completion. busy-high cycles are counted.
  task automatic run_op(input bit sel_b, input bit on, input bit disturb,
                        output int cyc, output bit ok, output bit er);
    logic d, e, bz;
    cyc = 0; ok = 1'b0; er = 1'b0;
    @(negedge clk);
    if (sel_b) b_clr = 1'b1; else a_clr = 1'b1;
    @(negedge clk);
    a_clr = 1'b0; b_clr = 1'b0;
    if (sel_b) begin b_on = on; b_off = !on; end
    else       begin a_on = on; a_off = !on; end
    @(negedge clk);
    a_on = 1'b0; a_off = 1'b0; b_on = 1'b0; b_off = 1'b0;
    for (int k = 0; k < 400; k++) begin
      d  = sel_b ? b_done : a_done;
      e  = sel_b ? b_err  : a_err;
      bz = sel_b ? b_busy : a_busy;
      if (d || e) begin ok = d; er = e; break; end
      if (bz) cyc++;
      if (disturb && cyc == 3) begin
        if (sel_b) begin b_on = !on; b_off = on; end
        else       begin a_on = !on; a_off = on; end
      end else begin
        a_on = 1'b0; a_off = 1'b0; b_on = 1'b0; b_off = 1'b0;
      end
      @(negedge clk);
    end
    // R9/R11: neither completion pulse may persist; busy already low
    chk("R11 busy low at completion", sel_b ? b_busy : a_busy, 0);
    @(negedge clk);
    chk("R11 done one cycle", sel_b ? b_done : a_done, 0);
    chk("R9 error one cycle", sel_b ? b_err : a_err, 0);
    @(negedge clk);
  endtask

  task automatic chk_off_a(string rq);
    chk({rq, " pri"}, a_pri, 0);  chk({rq, " sec"}, a_sec, 0);
    chk({rq, " iso"}, a_iso, 1);  chk({rq, " rstn"}, a_rstn, 0);
    chk({rq, " gate"}, a_gate, 1); chk({rq, " pdn"}, a_pdn, 15);
    chk({rq, " prot"}, a_prot, 1);
  endtask

  task automatic chk_on_a(string rq);
    chk({rq, " pri"}, a_pri, 1);  chk({rq, " sec"}, a_sec, 1);
    chk({rq, " iso"}, a_iso, 0);  chk({rq, " rstn"}, a_rstn, 1);
    chk({rq, " gate"}, a_gate, 0); chk({rq, " pdn"}, a_pdn, 0);
    chk({rq, " prot"}, a_prot, 0);
  endtask

  initial begin
    int cyc;
    bit ok, er;
    a_on = 0; a_off = 0; a_hsec = 0; a_hack = 0; a_hprot = 0; a_clr = 0;
    b_on = 0; b_off = 0; b_clr = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    chk_off_a("R1 reset");
    chk("R1 busy", a_busy, 0); chk("R1 done", a_done, 0); chk("R1 err", a_err, 0);
    chk("R1 min prot", b_prot, 0); chk("R1 min pdn", b_pdn, 15);

    // R2 R3 R4 R7 R10 R11: full power-up with an opposite request while busy
    run_op(1'b0, 1'b1, 1'b1, cyc, ok, er);
    chk("R4 up done", ok, 1); chk("R9 up no error", er, 0);
    chk_log(1'b0, "R2 R4 R10 up", 7, '{1, 2, 3, 4, 5, 6, 7, 0});
    chk_on_a("R4 up final");

    // R5 R6: full power-down
    run_op(1'b0, 1'b0, 1'b0, cyc, ok, er);
    chk("R6 down done", ok, 1); chk("R9 down no error", er, 0);
    chk_log(1'b0, "R5 R6 down", 7, '{8, 9, 10, 11, 12, 13, 14, 0});
    chk_off_a("R6 down final");

    // R3 R9: secondary status frozen low -> mixed state, timeout, outputs held
    a_hsec = 1'b1;
    run_op(1'b0, 1'b1, 1'b0, cyc, ok, er);
    chk("R3 mixed no done", ok, 0); chk("R9 mixed error", er, 1);
    chk("R9 stat wait length", cyc, TMO + 2);
    chk_log(1'b0, "R3 mixed", 2, '{1, 2, 0, 0, 0, 0, 0, 0});
    chk("R3 gate held", a_gate, 1); chk("R9 pri held", a_pri, 1);
    chk("R9 sec held", a_sec, 1); chk("R9 busy idle", a_busy, 0);
    a_hsec = 1'b0;
    run_op(1'b0, 1'b0, 1'b0, cyc, ok, er);
    chk("R6 recover down", ok, 1);
    chk_off_a("R6 recover final");

    // R4 R9: memory acknowledgements frozen high on power-up
    a_hack = 1'b1;
    run_op(1'b0, 1'b1, 1'b0, cyc, ok, er);
    chk("R9 mem wait error", er, 1);
    chk_log(1'b0, "R4 mem stall", 6, '{1, 2, 3, 4, 5, 6, 0, 0});
    chk("R4 prot kept until mem ack", a_prot, 1);
    chk("R9 rstn held", a_rstn, 1); chk("R9 pdn held", a_pdn, 0);
    a_hack = 1'b0;
    run_op(1'b0, 1'b0, 1'b0, cyc, ok, er);
    chk("R5 down after mem stall", ok, 1);

    // R5 R9: protection grant never arrives on power-down
    run_op(1'b0, 1'b1, 1'b0, cyc, ok, er);
    chk("R4 second up", ok, 1);
    a_hprot = 1'b1;
    run_op(1'b0, 1'b0, 1'b0, cyc, ok, er);
    chk("R9 prot wait error", er, 1);
    chk("R9 prot wait length", cyc, TMO + 1);
    chk_log(1'b0, "R5 prot stall", 1, '{8, 0, 0, 0, 0, 0, 0, 0});
    chk("R5 mem untouched", a_pdn, 0); chk("R5 iso untouched", a_iso, 0);
    a_hprot = 1'b0;
    run_op(1'b0, 1'b0, 1'b0, cyc, ok, er);
    chk("R5 down after grant", ok, 1);
    chk_off_a("R5 final");

    // R7 R8: minimal instance, no acks, no protection
    run_op(1'b1, 1'b1, 1'b0, cyc, ok, er);
    chk("R7 min up done", ok, 1); chk("R7 min up no error", er, 0);
    chk_log(1'b1, "R7 R8 min up", 6, '{1, 2, 3, 4, 5, 6, 0, 0});
    chk("R8 min prot low", b_prot, 0);
    run_op(1'b1, 1'b0, 1'b0, cyc, ok, er);
    chk("R7 min down done", ok, 1);
    chk_log(1'b1, "R7 R8 min down", 6, '{9, 10, 11, 12, 13, 14, 0, 0});
    chk("R8 min prot still low", b_prot, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule